// File: doc/BRIEF.md
# Reset Button Hold-Time Meter

This block measures how long an active-low push button has been held, so that firmware can tell a short reset tap from a deliberate long press that should start a factory reset. The button input is asynchronous. It passes through a two-flop synchronizer. While the synchronized level is low, a saturating counter advances once per reference-clock cycle. At the default 25 MHz reference, one count is 40 ns and the 29-bit range covers about 21.4 s.

When the button is released, the count freezes. A later press continues counting from the frozen value. Software reads the count through a 32-bit register port. Writing that register with bit 31 set returns the count to zero.

A comparator checks the count against a threshold given in whole seconds, where one second is `TICKS_PER_SEC` counts. When the count reaches that threshold, the comparator raises a registered long-press flag. The flag stays up until the next clear.

Top module: `rsthold_meter`

## Requirements
- R1: After reset, with the button released, the count is 0, `long_press` is 0 and `reg_rdata` reads 0.
- R2: The button passes through two synchronizer flops before it affects counting. A press that the clock samples low on K edges adds exactly K to the count, and that total is visible two cycles after release.
- R3: While the synchronized button is low, the count rises by one on each clock. The count is returned in `reg_rdata[CNT_W-1:0]`, which is bits 28:0 at the default width.
- R4: The count saturates at 2^CNT_W-1 and never wraps.
- R5: While the button is released, the count holds its value. A new press continues counting from the held value.
- R6: A write with `reg_wdata[31]`=1 sets the count to 0 on the next clock. A write with bit 31 = 0 leaves the count unchanged.
- R7: `reg_rdata` bits 30 down to CNT_W read 0. `reg_rdata[31]` reads 1 while the synchronized button is low and 0 otherwise.
- R8: The flag is set one clock after the count becomes nonzero and at least `thresh_sec`×`TICKS_PER_SEC`. It stays 0 while the count is below that value. A threshold of 0 sets the flag on the first count.
- R9: Once set, `long_press` stays 1 after the button is released. It stays 1 until a clear write, which drops it on the same clock that zeroes the count.
- R10: A clear write during a press wins over the increment in that cycle. The count is 0 after the clear edge and resumes counting from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| btn_n | input | 1 | Asynchronous active-low button level |
| reg_wr | input | 1 | Write strobe for the count register |
| reg_wdata | input | 32 | Write data; bit 31 requests a clear |
| reg_rdata | output | 32 | Count, zero padding and live press status |
| thresh_sec | input | SEC_W | Long-press threshold in whole seconds |
| long_press | output | 1 | Registered, sticky long-press flag |

## Verification
The bound checker watches four behaviours on every cycle:
- The count never decreases except at a clear.
- The count stays still while the button is released.
- The count stays at its ceiling once it gets there.
- A clear zeroes both the count and the flag, and the flag never drops on its own.

Other behaviours need the bench's directed scenarios:
- the exact count that a press of known length produces through the synchronizer delay;
- the flag firing at the threshold boundary and not one count before it;
- clear-over-increment priority during a held press;
- the status bit and the zero padding as seen on the read port.

// File: rtl/rsthold_pkg.sv
package rsthold_pkg;
  localparam int REG_W    = 32;
  localparam int CLR_BIT  = 31;
  localparam int STAT_BIT = 31;
endpackage

// File: rtl/rsthold_sync.sv
module rsthold_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= 1'b1;
          else        chain[s] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= 1'b1;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/rsthold_count.sv
module rsthold_count #(
  parameter int CNT_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pressed,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             at_ceiling
);
  localparam logic [CNT_W-1:0] CEIL = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] v,
                                            input logic run);
    if (run && v != CEIL) return v + 1'b1;
    return v;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= step(cnt, pressed);
  end

  assign at_ceiling = (cnt == CEIL);
endmodule

// File: rtl/rsthold_cmp.sv
module rsthold_cmp #(
  parameter int CNT_W         = 29,
  parameter int SEC_W         = 8,
  parameter int TICKS_PER_SEC = 25_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic [SEC_W-1:0] thresh_sec,
  input  logic             clr,
  output logic             hit,
  output logic             flag
);
  localparam int LIM_W = SEC_W + 32;

  function automatic logic [LIM_W-1:0] limit_of(input logic [SEC_W-1:0] sec);
    logic [LIM_W-1:0] t;
    t = LIM_W'(TICKS_PER_SEC);
    return LIM_W'(sec) * t;
  endfunction

  assign hit = (cnt != '0) && (LIM_W'(cnt) >= limit_of(thresh_sec));

  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (clr) flag <= 1'b0;
    else if (hit) flag <= 1'b1;
  end
endmodule

// File: rtl/rsthold_meter.sv
module rsthold_meter #(
  parameter int CNT_W         = 29,
  parameter int SEC_W         = 8,
  parameter int TICKS_PER_SEC = 25_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             btn_n,
  input  logic             reg_wr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [SEC_W-1:0] thresh_sec,
  output logic             long_press
);
  import rsthold_pkg::*;

  localparam int PAD_W = REG_W - 1 - CNT_W;

  logic             btn_sync;
  logic             pressed_s;
  logic             clr_hit;
  logic [CNT_W-1:0] cnt_q;
  logic             ceil_s;
  logic             hit_s;

  rsthold_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(btn_n), .q_sync(btn_sync)
  );

  assign pressed_s = ~btn_sync;
  assign clr_hit   = reg_wr & reg_wdata[CLR_BIT];

  rsthold_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .pressed(pressed_s), .clr(clr_hit),
    .cnt(cnt_q), .at_ceiling(ceil_s)
  );

  rsthold_cmp #(.CNT_W(CNT_W), .SEC_W(SEC_W), .TICKS_PER_SEC(TICKS_PER_SEC)) u_cmp (
    .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .thresh_sec(thresh_sec),
    .clr(clr_hit), .hit(hit_s), .flag(long_press)
  );

  assign reg_rdata = {pressed_s, {PAD_W{1'b0}}, cnt_q};
endmodule

// File: rtl/rsthold_meter_chk.sv
module rsthold_meter_chk #(
  parameter int CNT_W = 29
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt,
  input logic             pressed,
  input logic             clr,
  input logic             flag
);
  localparam logic [CNT_W-1:0] CEIL = {CNT_W{1'b1}};

  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt >= $past(cnt)));

  assert_hold_ceiling_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CEIL && !clr) |=> (cnt == CEIL));

  assert_freeze_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pressed && !clr) |=> $stable(cnt));

  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0 && !flag));

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
endmodule

bind rsthold_meter rsthold_meter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .pressed(pressed_s),
  .clr(clr_hit), .flag(long_press)
);

// File: tb/rsthold_meter_bench.sv
module rsthold_meter_bench;
  localparam int CNT_W = 8;
  localparam int SEC_W = 4;
  localparam int TPS   = 10;
  localparam logic [31:0] CEIL = 32'd255;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn_n = 1'b1;
  logic reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [SEC_W-1:0] thresh_sec = '0;
  logic long_press;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  rsthold_meter #(.CNT_W(CNT_W), .SEC_W(SEC_W), .TICKS_PER_SEC(TPS)) u_rsthold_meter (
    .clk(clk), .rst_n(rst_n), .btn_n(btn_n), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .thresh_sec(thresh_sec), .long_press(long_press)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic press(input int k);
    @(negedge clk) btn_n = 1'b0;
    repeat (k) @(negedge clk);
    btn_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic reg_write(input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic t_reset_R1();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdata", reg_rdata, 32'd0);
    check("R1 flag", {31'd0, long_press}, 32'd0);
  endtask

  task automatic t_count_R2_R3();
    thresh_sec = 4'd15;
    press(7);
    check("R2 R3 press of 7", reg_rdata, 32'd7);
    press(1);
    check("R5 resume +1", reg_rdata, 32'd8);
    reg_write(32'h8000_0000);
    check("R6 clear", reg_rdata, 32'd0);
  endtask

  task automatic t_status_R7();
    @(negedge clk) btn_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R7 status while low", {reg_rdata[31], 31'd0}, 32'h8000_0000);
    check("R3 count mid-press", {1'b0, reg_rdata[30:0]}, 32'd2);
    btn_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 status released", reg_rdata, 32'd4);
    repeat (5) @(negedge clk);
    check("R5 frozen", reg_rdata, 32'd4);
  endtask

  task automatic t_nonclear_R6();
    reg_write(32'h7FFF_FFFF);
    check("R6 write without bit31", reg_rdata, 32'd4);
    reg_write(32'h8000_0000);
    check("R6 clear", reg_rdata, 32'd0);
  endtask

  task automatic t_priority_R10();
    @(negedge clk) btn_n = 1'b0;
    repeat (6) @(negedge clk);
    reg_wr = 1'b1; reg_wdata = 32'h8000_0000;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
    check("R10 clear beats increment", {1'b0, reg_rdata[30:0]}, 32'd0);
    @(negedge clk);
    check("R10 resumes after clear", {1'b0, reg_rdata[30:0]}, 32'd1);
    btn_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 total after clear", reg_rdata, 32'd3);
    reg_write(32'h8000_0000);
  endtask

  task automatic t_threshold_R8_R9();
    thresh_sec = 4'd3;
    press(29);
    check("R8 below threshold", {31'd0, long_press}, 32'd0);
    check("R8 count 29", reg_rdata, 32'd29);
    press(1);
    check("R8 at threshold", {31'd0, long_press}, 32'd1);
    repeat (10) @(negedge clk);
    check("R9 sticky after release", {31'd0, long_press}, 32'd1);
    reg_write(32'h8000_0000);
    check("R9 flag cleared", {31'd0, long_press}, 32'd0);
    thresh_sec = 4'd0;
    repeat (2) @(negedge clk);
    check("R8 zero thresh idle", {31'd0, long_press}, 32'd0);
    press(1);
    check("R8 zero thresh first count", {31'd0, long_press}, 32'd1);
    reg_write(32'h8000_0000);
  endtask

  task automatic t_saturate_R4();
    thresh_sec = 4'd15;
    press(300);
    check("R4 saturates", reg_rdata, CEIL);
    check("R8 limit 150 reached", {31'd0, long_press}, 32'd1);
    press(5);
    check("R4 no wrap", reg_rdata, CEIL);
    reg_write(32'h8000_0000);
    check("R6 clear from ceiling", reg_rdata, 32'd0);
  endtask

  initial begin
    fork
      begin
        t_reset_R1();
        t_count_R2_R3();
        t_status_R7();
        t_nonclear_R6();
        t_priority_R10();
        t_threshold_R8_R9();
        t_saturate_R4();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule